// File: doc/BRIEF.md
# Programmable SCL Period Generator

This block times the clock line of a two-wire serial bus master. A 2-bit speed selector chooses one of three pairs of programmed counts (standard, fast, high speed). The chosen low count decides how long the generator pulls SCL low. The chosen high count, a programmable spike-filter length and a fixed overhead together decide how long SCL is left released and high. The pair is captured at the start of each phase, so reprogramming takes effect from the next phase.

The sampled SCL line goes through a spike filter before the generator looks at it. The high phase is timed only once the filtered line reads high, so a slow rising edge or a target that holds the line low (clock stretching) lengthens the period. Inside every low phase the block gives the bit engine two strobes that mark when SDA may change: one at the transmit hold offset and one at the receive hold offset, both counted from the falling edge. It also gives one-cycle strobes at the end of each low and each high phase. While `run` is high, periods follow one another without a gap. When `run` is low at the end of a high phase, SCL stays released.

Top module: `scl_period_gen`

## Requirements
- R1: After reset SCL is released (`scl_drive_low`=0) and all four strobes are low.
- R2: `speed_sel` picks the count pair: 0 standard, 1 fast, 2 high speed, 3 standard. The pair is captured when a phase starts, and later changes to the selector or the counts do not alter that phase.
- R3: A low phase starts on the cycle after `run` is seen high while idle, or right after a high phase ends with `run` high. `scl_drive_low` stays 1 for exactly low count + 1 cycles, and `low_end` pulses on the last of them.
- R4: After a low phase, SCL is released. The cycle after the generator sees filtered SCL high, the high phase begins and lasts high count + spike length + 7 cycles, with `high_end` pulsing on its last cycle. `low_end` and `high_end` never pulse together.
- R5: While filtered SCL stays low after release (stretching), the generator waits with SCL released and no strobe, for as long as it takes.
- R6: The filtered SCL takes a new level only after the raw input has differed from it for spike length + 1 consecutive cycles. Shorter pulses are ignored.
- R7: `sda_tx_ok` is a one-cycle pulse in the low-phase cycle whose index equals `tx_hold`, where index 0 is the first low cycle. If `tx_hold` exceeds the last index, it pulses on the last low cycle instead.
- R8: `sda_rx_ok` follows the same rule as R7, using `rx_hold`.
- R9: If `run` is low when a high phase ends, the generator goes idle and keeps SCL released. Otherwise the next low phase starts on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Keep generating SCL periods |
| speed_sel | input | 2 | Selects the count pair (0 std, 1 fast, 2 high speed, 3 std) |
| std_hi | input | 16 | Standard-mode high count |
| std_lo | input | 16 | Standard-mode low count |
| fast_hi | input | 16 | Fast-mode high count |
| fast_lo | input | 16 | Fast-mode low count |
| hs_hi | input | 16 | High-speed high count |
| hs_lo | input | 16 | High-speed low count |
| spike_len | input | 8 | Spike-filter length in cycles |
| tx_hold | input | 16 | Transmit SDA hold, in cycles after the SCL fall |
| rx_hold | input | 8 | Receive SDA hold, in cycles after the SCL fall |
| scl_in | input | 1 | Sampled SCL line |
| scl_drive_low | output | 1 | Request to pull SCL low |
| sda_tx_ok | output | 1 | Transmit SDA may change (strobe) |
| sda_rx_ok | output | 1 | Receive SDA may change (strobe) |
| low_end | output | 1 | Last cycle of a low phase |
| high_end | output | 1 | Last cycle of a high phase |

## Verification
The bench keeps the default widths (16-bit counts, 8-bit spike length) and programs small counts, down to a low count of 0. A one-cycle low phase and a transmit hold larger than the low phase are therefore covered, and each period lasts only a few tens of cycles. Spike lengths of 0, 2 and 3 exercise the filter's rejection of short pulses and the extra delay it adds to the release edge. A stretching target with glitches injected into it shows that the high phase waits for a stable line.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

    localparam logic [1:0] SPD_STD  = 2'd0;
    localparam logic [1:0] SPD_FAST = 2'd1;
    localparam logic [1:0] SPD_HS   = 2'd2;

    // cycles added to the high phase beyond count + spike length (limit is inclusive)
    localparam int unsigned HIGH_FIXED = 6;

endpackage

// File: rtl/sclg_spike_filter.sv
module sclg_spike_filter #(
    parameter int SPK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic [SPK_W-1:0] spk_len,
    output logic             filt
);

    typedef struct packed {
        logic             lvl;
        logic [SPK_W-1:0] run_cnt;
    } flt_t;

    flt_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (raw != s_q.lvl) begin
            if (s_q.run_cnt >= spk_len) begin
                s_d.lvl     = raw;
                s_d.run_cnt = '0;
            end else begin
                s_d.run_cnt = s_q.run_cnt + 1'b1;
            end
        end else begin
            s_d.run_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.lvl     <= 1'b1;
            s_q.run_cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign filt = s_q.lvl;

endmodule

// File: rtl/sclg_pair_sel.sv
module sclg_pair_sel #(
    parameter int CNT_W = 16
) (
    input  logic [1:0]       speed_sel,
    input  logic [CNT_W-1:0] std_hi,
    input  logic [CNT_W-1:0] std_lo,
    input  logic [CNT_W-1:0] fast_hi,
    input  logic [CNT_W-1:0] fast_lo,
    input  logic [CNT_W-1:0] hs_hi,
    input  logic [CNT_W-1:0] hs_lo,
    output logic [CNT_W-1:0] hi_sel,
    output logic [CNT_W-1:0] lo_sel
);
    import scl_gen_pkg::*;

    always_comb begin
        unique case (speed_sel)
            SPD_FAST: begin hi_sel = fast_hi; lo_sel = fast_lo; end
            SPD_HS:   begin hi_sel = hs_hi;   lo_sel = hs_lo;   end
            default:  begin hi_sel = std_hi;  lo_sel = std_lo;  end
        endcase
    end

endmodule

// File: rtl/sclg_hold_strobe.sv
module sclg_hold_strobe #(
    parameter int HW    = 16,
    parameter int CTR_W = 17
) (
    input  logic             in_low,
    input  logic [CTR_W-1:0] idx,
    input  logic [CTR_W-1:0] lim,
    input  logic [HW-1:0]    hold,
    output logic             strobe
);

    logic [CTR_W-1:0] hold_x;

    assign hold_x = CTR_W'(hold);
    assign strobe = in_low && ((idx == hold_x) || ((idx == lim) && (hold_x > lim)));

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
    parameter int CNT_W  = 16,
    parameter int SPK_W  = 8,
    parameter int TXH_W  = 16,
    parameter int RXH_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       speed_sel,
    input  logic [CNT_W-1:0] std_hi,
    input  logic [CNT_W-1:0] std_lo,
    input  logic [CNT_W-1:0] fast_hi,
    input  logic [CNT_W-1:0] fast_lo,
    input  logic [CNT_W-1:0] hs_hi,
    input  logic [CNT_W-1:0] hs_lo,
    input  logic [SPK_W-1:0] spike_len,
    input  logic [TXH_W-1:0] tx_hold,
    input  logic [RXH_W-1:0] rx_hold,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             sda_tx_ok,
    output logic             sda_rx_ok,
    output logic             low_end,
    output logic             high_end
);
    import scl_gen_pkg::*;

    localparam int BASE_W = (CNT_W > SPK_W) ? CNT_W : SPK_W;
    localparam int CTR_W  = BASE_W + 2;

    typedef struct packed {
        phase_e           ph;
        logic [CTR_W-1:0] idx;
        logic [CTR_W-1:0] lim;
    } fsm_t;

    fsm_t f_d, f_q;

    logic             scl_filt;
    logic [CNT_W-1:0] hi_sel, lo_sel;
    logic [CTR_W-1:0] hi_lim, lo_lim;
    logic             last, in_low;

    sclg_spike_filter #(.SPK_W(SPK_W)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (scl_in),
        .spk_len (spike_len),
        .filt    (scl_filt)
    );

    sclg_pair_sel #(.CNT_W(CNT_W)) u_sel (
        .speed_sel (speed_sel),
        .std_hi    (std_hi),
        .std_lo    (std_lo),
        .fast_hi   (fast_hi),
        .fast_lo   (fast_lo),
        .hs_hi     (hs_hi),
        .hs_lo     (hs_lo),
        .hi_sel    (hi_sel),
        .lo_sel    (lo_sel)
    );

    assign hi_lim = CTR_W'(hi_sel) + CTR_W'(spike_len) + CTR_W'(HIGH_FIXED);
    assign lo_lim = CTR_W'(lo_sel);
    assign last   = (f_q.idx == f_q.lim);
    assign in_low = (f_q.ph == PH_LOW);

    always_comb begin
        f_d = f_q;
        unique case (f_q.ph)
            PH_IDLE: begin
                if (run) begin
                    f_d.ph  = PH_LOW;
                    f_d.idx = '0;
                    f_d.lim = lo_lim;
                end
            end
            PH_LOW: begin
                if (last) f_d.ph  = PH_WAIT;
                else      f_d.idx = f_q.idx + 1'b1;
            end
            PH_WAIT: begin
                if (scl_filt) begin
                    f_d.ph  = PH_HIGH;
                    f_d.idx = '0;
                    f_d.lim = hi_lim;
                end
            end
            PH_HIGH: begin
                if (last) begin
                    if (run) begin
                        f_d.ph  = PH_LOW;
                        f_d.idx = '0;
                        f_d.lim = lo_lim;
                    end else begin
                        f_d.ph  = PH_IDLE;
                    end
                end else begin
                    f_d.idx = f_q.idx + 1'b1;
                end
            end
            default: f_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.ph  <= PH_IDLE;
            f_q.idx <= '0;
            f_q.lim <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    sclg_hold_strobe #(.HW(TXH_W), .CTR_W(CTR_W)) u_tx_hold (
        .in_low (in_low),
        .idx    (f_q.idx),
        .lim    (f_q.lim),
        .hold   (tx_hold),
        .strobe (sda_tx_ok)
    );

    sclg_hold_strobe #(.HW(RXH_W), .CTR_W(CTR_W)) u_rx_hold (
        .in_low (in_low),
        .idx    (f_q.idx),
        .lim    (f_q.lim),
        .hold   (rx_hold),
        .strobe (sda_rx_ok)
    );

    assign scl_drive_low = in_low;
    assign low_end       = in_low && last;
    assign high_end      = (f_q.ph == PH_HIGH) && last;

endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic scl_drive_low,
    input logic sda_tx_ok,
    input logic sda_rx_ok,
    input logic low_end,
    input logic high_end
);

    p_ends_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(low_end && high_end));

    p_lowend_in_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        low_end |-> scl_drive_low);

    p_release_after_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        low_end |=> !scl_drive_low);

    p_high_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        high_end |-> !scl_drive_low);

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (high_end && run) |=> scl_drive_low);

    p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (high_end && !run) |=> !scl_drive_low);

    p_tx_in_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sda_tx_ok |-> scl_drive_low);

    p_tx_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sda_tx_ok |=> !sda_tx_ok);

    p_rx_in_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sda_rx_ok |-> scl_drive_low);

    p_rx_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sda_rx_ok |=> !sda_rx_ok);

endmodule

bind scl_period_gen scl_period_gen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .scl_drive_low (scl_drive_low),
    .sda_tx_ok     (sda_tx_ok),
    .sda_rx_ok     (sda_rx_ok),
    .low_end       (low_end),
    .high_end      (high_end)
);

// File: tb/tb_scl_period_gen.sv
`timescale 1ns/1ps
module tb_scl_period_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  speed_sel = 2'd0;
    logic [15:0] std_hi = 16'd5, std_lo = 16'd4;
    logic [15:0] fast_hi = 16'd3, fast_lo = 16'd2;
    logic [15:0] hs_hi = 16'd1, hs_lo = 16'd0;
    logic [7:0]  spike_len = 8'd0;
    logic [15:0] tx_hold = 16'd2;
    logic [7:0]  rx_hold = 8'd1;
    logic        scl_in = 1'b1;
    logic        stretch = 1'b0, glitch = 1'b0;
    logic        scl_drive_low, sda_tx_ok, sda_rx_ok, low_end, high_end;

    int checks = 0, errors = 0;
    int high_seen = 0, low_cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    scl_period_gen dut (
        .clk(clk), .rst_n(rst_n), .run(run), .speed_sel(speed_sel),
        .std_hi(std_hi), .std_lo(std_lo), .fast_hi(fast_hi), .fast_lo(fast_lo),
        .hs_hi(hs_hi), .hs_lo(hs_lo), .spike_len(spike_len),
        .tx_hold(tx_hold), .rx_hold(rx_hold), .scl_in(scl_in),
        .scl_drive_low(scl_drive_low), .sda_tx_ok(sda_tx_ok), .sda_rx_ok(sda_rx_ok),
        .low_end(low_end), .high_end(high_end)
    );

    // bus: wired-AND of our drive and a stretching target, plus injected glitches
    always @(negedge clk) scl_in = glitch | !(scl_drive_low | stretch);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_filt = 1, m_run = 0, m_ph = 0, m_idx = 0, m_lim = 0;  // ph: 0 idle 1 low 2 wait 3 high

    function automatic int pick_lo(input int sp);
        if (sp == 1) return fast_lo;
        if (sp == 2) return hs_lo;
        return std_lo;
    endfunction
    function automatic int pick_hi(input int sp);
        if (sp == 1) return fast_hi;
        if (sp == 2) return hs_hi;
        return std_hi;
    endfunction

    always @(posedge clk) begin
        int c_rst, c_run, c_sp, c_in, c_spk, c_lo, c_hi, old_filt;
        int e_drv, e_le, e_he, e_tx, e_rx, htx, hrx;
        c_rst = rst_n; c_run = run; c_sp = speed_sel; c_in = scl_in;
        c_spk = spike_len; c_lo = pick_lo(speed_sel); c_hi = pick_hi(speed_sel);
        #1;
        if (!c_rst) begin
            m_filt = 1; m_run = 0; m_ph = 0; m_idx = 0; m_lim = 0;
        end else begin
            old_filt = m_filt;
            if (c_in != m_filt) begin
                if (m_run >= c_spk) begin m_filt = c_in; m_run = 0; end
                else m_run++;
            end else m_run = 0;
            case (m_ph)
                0: if (c_run) begin m_ph = 1; m_idx = 0; m_lim = c_lo; end
                1: if (m_idx == m_lim) m_ph = 2; else m_idx++;
                2: if (old_filt) begin m_ph = 3; m_idx = 0; m_lim = c_hi + c_spk + 6; end
                default: if (m_idx == m_lim) begin
                    if (c_run) begin m_ph = 1; m_idx = 0; m_lim = c_lo; end
                    else m_ph = 0;
                end else m_idx++;
            endcase
        end
        htx = tx_hold; hrx = rx_hold;
        e_drv = (m_ph == 1);
        e_le  = (m_ph == 1) && (m_idx == m_lim);
        e_he  = (m_ph == 3) && (m_idx == m_lim);
        e_tx  = e_drv && ((m_idx == htx) || (m_idx == m_lim && htx > m_lim));
        e_rx  = e_drv && ((m_idx == hrx) || (m_idx == m_lim && hrx > m_lim));
        check(scl_drive_low == e_drv, "R2 R3 scl_drive_low", scl_drive_low, e_drv);
        check(low_end == e_le, "R3 low_end", low_end, e_le);
        check(high_end == e_he, "R4 high_end", high_end, e_he);
        check(sda_tx_ok == e_tx, "R7 sda_tx_ok", sda_tx_ok, e_tx);
        check(sda_rx_ok == e_rx, "R8 sda_rx_ok", sda_rx_ok, e_rx);
        if (high_end) high_seen++;
        if (scl_drive_low) low_cycles++;
    end

    // ---------------- stimulus ----------------
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic measure_low(input int switch_to, output int n);
        while (scl_drive_low) tick(1);
        while (!scl_drive_low) tick(1);
        if (switch_to >= 0) speed_sel = 2'(switch_to);
        n = 0;
        while (scl_drive_low) begin n++; tick(1); end
    endtask

    initial begin
        int n, h0, l0;
        tick(3);
        check(scl_drive_low == 0 && low_end == 0 && high_end == 0 &&
              sda_tx_ok == 0 && sda_rx_ok == 0, "R1 reset outputs",
              {scl_drive_low, low_end, high_end, sda_tx_ok, sda_rx_ok}, 0);
        rst_n = 1'b1;
        run = 1'b1;
        tick(60);
        measure_low(-1, n);
        check(n == 5, "R3 std low length", n, 5);

        speed_sel = 2'd1; spike_len = 8'd3;
        tick(80);
        measure_low(-1, n);
        check(n == 3, "R2 fast low length", n, 3);

        speed_sel = 2'd2; spike_len = 8'd0;
        tick(40);
        measure_low(-1, n);
        check(n == 1, "R2 hs low length", n, 1);

        speed_sel = 2'd3;
        tick(60);
        measure_low(-1, n);
        check(n == 5, "R2 code 3 acts as std", n, 5);

        // selector switched during a std low phase: phase keeps its captured length
        speed_sel = 2'd0;
        tick(30);
        measure_low(2, n);
        check(n == 5, "R2 pair captured at phase start", n, 5);
        speed_sel = 2'd0;
        tick(30);

        // stretching with short glitches (spike length 2 -> 3 stable cycles needed)
        spike_len = 8'd2;
        while (!low_end) tick(1);
        stretch = 1'b1;
        tick(2);
        h0 = high_seen; l0 = low_cycles;
        tick(5);
        glitch = 1'b1; tick(2); glitch = 1'b0;
        tick(4);
        glitch = 1'b1; tick(1); glitch = 1'b0;
        tick(10);
        check(high_seen == h0, "R5 no high phase while stretched", high_seen - h0, 0);
        check(low_cycles == l0, "R5 SCL stays released while stretched", low_cycles - l0, 0);
        check(high_seen == h0, "R6 short glitches rejected", high_seen - h0, 0);
        stretch = 1'b0;
        tick(40);
        check(high_seen > h0, "R4 high phase after stretch release", high_seen - h0, 1);

        // transmit hold beyond low phase is clamped to its last cycle
        tx_hold = 16'd9; rx_hold = 8'd0;
        tick(60);

        // stop
        run = 1'b0;
        tick(50);
        h0 = high_seen; l0 = low_cycles;
        tick(20);
        check(scl_drive_low == 0, "R9 released when idle", scl_drive_low, 0);
        check(low_cycles == l0 && high_seen == h0, "R9 no further periods",
              low_cycles - l0, 0);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule